// File: doc/BRIEF.md
# Latched Serial-to-Parallel Register

This block collects a serial bit stream into a row of shift stages and holds a snapshot of those stages in a separate output buffer, so the parallel outputs change only when the user decides. A shift strobe moves the serial input into the lowest stage and pushes every other stage one place up. The top stage is also brought out alone so that several blocks can be chained. A latch strobe copies the stages into the buffer. Two clear inputs act independently, one on the stages and one on the buffer.

Both strobes are ordinary data inputs sampled on the system clock. A strobe acts once, on the first clock at which it is seen high after being low. An enable input is interpreted in one of three ways, chosen at build time: power-down (content is wiped while disabled), mute (only the parallel outputs are forced low), or input gating (shift strobes are ignored and the content is kept).

Top module: `sipo_latched_reg`

## Requirements
- R1: A low-to-high change of `shift_clk`, seen between two consecutive system clock samples, moves `ser_in` into stage bit 0 and every stage bit i into bit i+1 at that clock edge; holding `shift_clk` high causes no further shifts.
- R2: `cascade_out` always equals the top stage bit (bit WIDTH-1).
- R3: `stage_clr` high at a clock edge clears all stages at that edge, and it wins over a shift strobe in the same cycle.
- R4: A low-to-high change of `latch_clk` copies the stages into the buffer at that clock edge; `par_out` bit i shows buffer bit i when not muted.
- R5: `buf_clr` high at a clock edge clears the buffer without changing the stages, and it wins over a latch strobe in the same cycle.
- R6: In power-down mode (`ENA_MODE` = SIPO_EN_POWERDOWN), while `en` is low the stages and buffer are zero, so `par_out` and `cascade_out` are zero, strobes have no effect, and the content stays zero after `en` returns high.
- R7: In mute mode (`ENA_MODE` = SIPO_EN_MUTE), while `en` is low `par_out` is zero but shifting, latching and clears still update the content, which appears on `par_out` when `en` returns high; `cascade_out` is not muted.
- R8: In gating mode (`ENA_MODE` = SIPO_EN_GATE), while `en` is low shift strobes are ignored and the stages are kept, while latch strobes and both clears still act and `par_out` stays visible.
- R9: After reset (`rst_n` low) the stages, the buffer, `par_out` and `cascade_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | 1 | Serial data bit |
| shift_clk | input | 1 | Shift strobe, acts on its rising change |
| stage_clr | input | 1 | Synchronous clear of the shift stages |
| latch_clk | input | 1 | Latch strobe, acts on its rising change |
| buf_clr | input | 1 | Synchronous clear of the output buffer |
| en | input | 1 | Enable, meaning chosen by ENA_MODE |
| par_out | output | WIDTH | Parallel outputs taken from the buffer |
| cascade_out | output | 1 | Top shift stage for chaining |

## Verification
Two pairs of functions can collide on one clock: a shift strobe with a stage clear, and a latch strobe with a buffer clear. The bench raises both inputs of a pair at the same falling clock edge so the same rising edge samples them, then expects all zeros on the affected storage, reading the stages through `cascade_out` and a later latch. After the buffer-clear collision it latches again to prove the stages kept their pattern. The same stimulus runs on three instances, one per enable mode, against a per-mode model.

// File: rtl/sipo_pkg.sv
package sipo_pkg;

  typedef enum logic [1:0] {
    SIPO_EN_POWERDOWN = 2'd0,
    SIPO_EN_MUTE      = 2'd1,
    SIPO_EN_GATE      = 2'd2
  } sipo_en_mode_e;

  // one shift step: new bit enters at bit 0, all others move up
  function automatic logic [63:0] shift_step(input logic [63:0] cur, input logic bit_in);
    return {cur[62:0], bit_in};
  endfunction

endpackage

// File: rtl/sipo_rise_det.sv
module sipo_rise_det (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= strobe_i;
  end

  assign rise_o = strobe_i & ~prev_q;

  // R1: a strobe held high yields one event only
  assert_single_event_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/sipo_stage_chain.sv
module sipo_stage_chain #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_i,
  input  logic             bit_i,
  input  logic             clr_i,
  input  logic             zero_i,
  output logic [WIDTH-1:0] stages_o
);
  localparam int PadW = 64 - WIDTH;

  logic [WIDTH-1:0] stages_q;
  logic [63:0]      wide_next;

  assign wide_next = sipo_pkg::shift_step({{PadW{1'b0}}, stages_q}, bit_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                stages_q <= '0;
    else if (clr_i || zero_i)  stages_q <= '0;
    else if (shift_i)          stages_q <= wide_next[WIDTH-1:0];
  end

  assign stages_o = stages_q;

  assert_stage_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (stages_o == '0));
  assert_stage_move_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_i && !clr_i && !zero_i) |=>
      (stages_o[0] == $past(bit_i)) && (stages_o[WIDTH-1:1] == $past(stages_o[WIDTH-2:0])));
  assert_stage_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_i && !clr_i && !zero_i) |=> $stable(stages_o));
endmodule

// File: rtl/sipo_hold_buf.sv
module sipo_hold_buf #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [WIDTH-1:0] src_i,
  input  logic             clr_i,
  input  logic             zero_i,
  output logic [WIDTH-1:0] buf_o
);
  logic [WIDTH-1:0] buf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               buf_q <= '0;
    else if (clr_i || zero_i) buf_q <= '0;
    else if (load_i)          buf_q <= src_i;
  end

  assign buf_o = buf_q;

  assert_buf_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (buf_o == '0));
  assert_buf_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !clr_i && !zero_i) |=> (buf_o == $past(src_i)));
  assert_buf_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !clr_i && !zero_i) |=> $stable(buf_o));
endmodule

// File: rtl/sipo_latched_reg.sv
module sipo_latched_reg #(
  parameter int                     WIDTH    = 8,
  parameter sipo_pkg::sipo_en_mode_e ENA_MODE = sipo_pkg::SIPO_EN_POWERDOWN
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_in,
  input  logic             shift_clk,
  input  logic             stage_clr,
  input  logic             latch_clk,
  input  logic             buf_clr,
  input  logic             en,
  output logic [WIDTH-1:0] par_out,
  output logic             cascade_out
);
  localparam bit IsPowerDown = (ENA_MODE == sipo_pkg::SIPO_EN_POWERDOWN);
  localparam bit IsMute      = (ENA_MODE == sipo_pkg::SIPO_EN_MUTE);
  localparam bit IsGate      = (ENA_MODE == sipo_pkg::SIPO_EN_GATE);

  // named internal events
  logic             shift_rise, latch_rise;
  logic             shift_ev, latch_ev;
  logic             wipe_all, out_muted;
  logic [WIDTH-1:0] stage_q, buf_q;

  sipo_rise_det u_shift_edge (.clk(clk), .rst_n(rst_n), .strobe_i(shift_clk), .rise_o(shift_rise));
  sipo_rise_det u_latch_edge (.clk(clk), .rst_n(rst_n), .strobe_i(latch_clk), .rise_o(latch_rise));

  assign wipe_all  = IsPowerDown && !en;
  assign out_muted = IsMute && !en;
  assign shift_ev  = shift_rise && !(IsGate && !en) && !wipe_all;
  assign latch_ev  = latch_rise && !wipe_all;

  sipo_stage_chain #(.WIDTH(WIDTH)) u_chain (
    .clk(clk), .rst_n(rst_n), .shift_i(shift_ev), .bit_i(ser_in),
    .clr_i(stage_clr), .zero_i(wipe_all), .stages_o(stage_q));

  sipo_hold_buf #(.WIDTH(WIDTH)) u_buf (
    .clk(clk), .rst_n(rst_n), .load_i(latch_ev), .src_i(stage_q),
    .clr_i(buf_clr), .zero_i(wipe_all), .buf_o(buf_q));

  generate
    if (IsMute) begin : g_mute_out
      assign par_out = out_muted ? '0 : buf_q;
    end else begin : g_plain_out
      assign par_out = buf_q;
    end
  endgenerate

  assign cascade_out = stage_q[WIDTH-1];

  // R5: buffer clear leaves the stages alone
  assert_bufclr_keeps_stages_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_clr && !stage_clr && !shift_rise && !wipe_all) |=> $stable(stage_q));

  generate
    if (IsPowerDown) begin : g_chk_pd
      assert_pd_wipe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (par_out == '0) && !cascade_out);
    end
    if (IsMute) begin : g_chk_mute
      assert_mute_out_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (par_out == '0));
    end
    if (IsGate) begin : g_chk_gate
      assert_gate_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !stage_clr) |=> $stable(stage_q));
    end
  endgenerate
endmodule

// File: tb/tb_sipo_latched_reg.sv
module tb_sipo_latched_reg;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_in = 1'b0, shift_clk = 1'b0, stage_clr = 1'b0;
  logic latch_clk = 1'b0, buf_clr = 1'b0, en = 1'b1;
  logic [W-1:0] par [3];
  logic         cas [3];

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // index 0 = power-down, 1 = mute, 2 = gating
  logic [W-1:0] m_st [3];
  logic [W-1:0] m_bf [3];

  always #2.5 clk = ~clk;

  sipo_lat_reg_inst_pd: begin end
  sipo_latched_reg #(.WIDTH(W), .ENA_MODE(sipo_pkg::SIPO_EN_POWERDOWN)) dut (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .shift_clk(shift_clk), .stage_clr(stage_clr),
    .latch_clk(latch_clk), .buf_clr(buf_clr), .en(en), .par_out(par[0]), .cascade_out(cas[0]));
  sipo_latched_reg #(.WIDTH(W), .ENA_MODE(sipo_pkg::SIPO_EN_MUTE)) dut_mute (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .shift_clk(shift_clk), .stage_clr(stage_clr),
    .latch_clk(latch_clk), .buf_clr(buf_clr), .en(en), .par_out(par[1]), .cascade_out(cas[1]));
  sipo_latched_reg #(.WIDTH(W), .ENA_MODE(sipo_pkg::SIPO_EN_GATE)) dut_gate (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .shift_clk(shift_clk), .stage_clr(stage_clr),
    .latch_clk(latch_clk), .buf_clr(buf_clr), .en(en), .par_out(par[2]), .cascade_out(cas[2]));

  task automatic check(input string rq, input int m, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s mode=%0d actual=%h expected=%h", rq, m, act, exp);
    end
  endtask

  // compare all three instances with the model
  task automatic check_all(input string rq);
    for (int m = 0; m < 3; m++) begin
      logic [W-1:0] ep;
      ep = (m == 1 && !en) ? '0 : m_bf[m];
      check({rq, " par_out"}, m, par[m], ep);
      check({rq, " cascade_out"}, m, {{(W-1){1'b0}}, cas[m]}, {{(W-1){1'b0}}, m_st[m][W-1]});
    end
  endtask

  task automatic shift_bit(input logic b);
    @(negedge clk); ser_in = b; shift_clk = 1'b1;
    @(negedge clk); shift_clk = 1'b0;
    for (int m = 0; m < 3; m++)
      if (en || m == 1) m_st[m] = {m_st[m][W-2:0], b};
  endtask

  task automatic shift_byte(input logic [W-1:0] v);
    for (int i = W - 1; i >= 0; i--) shift_bit(v[i]);
  endtask

  task automatic do_latch();
    @(negedge clk); latch_clk = 1'b1;
    @(negedge clk); latch_clk = 1'b0;
    for (int m = 0; m < 3; m++)
      if (en || m != 0) m_bf[m] = m_st[m];
  endtask

  task automatic set_en(input logic v);
    @(negedge clk); en = v;
    @(negedge clk);
    if (!v) begin m_st[0] = '0; m_bf[0] = '0; end
  endtask

  task automatic t_reset_R9();
    for (int m = 0; m < 3; m++) begin m_st[m] = '0; m_bf[m] = '0; end
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check_all("R9 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R9 after release");
  endtask

  task automatic t_shift_latch_R1_R4();
    shift_byte(8'hA5);
    check_all("R1 buffer unchanged before latch");
    check_all("R2 cascade after A5");
    do_latch();
    check_all("R4 latched A5");
    shift_byte(8'h3C);
    do_latch();
    check_all("R4 latched 3C");
  endtask

  task automatic t_hold_high_R1();
    @(negedge clk); ser_in = 1'b1; shift_clk = 1'b1;
    repeat (4) @(negedge clk);
    shift_clk = 1'b0;
    for (int m = 0; m < 3; m++) m_st[m] = {m_st[m][W-2:0], 1'b1};
    do_latch();
    check_all("R1 held strobe shifts once");
  endtask

  task automatic t_stage_clear_R3();
    shift_byte(8'hFF);
    @(negedge clk); stage_clr = 1'b1;
    @(negedge clk); stage_clr = 1'b0;
    for (int m = 0; m < 3; m++) m_st[m] = '0;
    check_all("R3 stage clear");
    do_latch();
    check_all("R3 cleared stages latched");
  endtask

  task automatic t_collide_shift_R3();
    shift_byte(8'h81);
    @(negedge clk); ser_in = 1'b1; shift_clk = 1'b1; stage_clr = 1'b1;
    @(negedge clk); shift_clk = 1'b0; stage_clr = 1'b0;
    for (int m = 0; m < 3; m++) m_st[m] = '0;
    check_all("R3 clear beats shift");
    do_latch();
    check_all("R3 collision latched");
  endtask

  task automatic t_buf_clear_R5();
    shift_byte(8'h96);
    do_latch();
    @(negedge clk); buf_clr = 1'b1;
    @(negedge clk); buf_clr = 1'b0;
    for (int m = 0; m < 3; m++) m_bf[m] = '0;
    check_all("R5 buffer clear");
    do_latch();
    check_all("R5 stages kept after buffer clear");
    @(negedge clk); latch_clk = 1'b1; buf_clr = 1'b1;
    @(negedge clk); latch_clk = 1'b0; buf_clr = 1'b0;
    for (int m = 0; m < 3; m++) m_bf[m] = '0;
    check_all("R5 clear beats latch");
    do_latch();
    check_all("R5 stages kept after collision");
  endtask

  task automatic t_disabled_R6_R7_R8();
    shift_byte(8'h5A);
    do_latch();
    set_en(1'b0);
    check_all("R6 R7 R8 right after disable");
    shift_bit(1'b1);
    shift_bit(1'b0);
    check_all("R6 R8 shift while disabled");
    do_latch();
    check_all("R7 R8 latch while disabled");
    set_en(1'b1);
    check_all("R6 R7 R8 after enable");
    do_latch();
    check_all("R6 R7 R8 relatched after enable");
    set_en(1'b0);
    @(negedge clk); stage_clr = 1'b1; buf_clr = 1'b1;
    @(negedge clk); stage_clr = 1'b0; buf_clr = 1'b0;
    for (int m = 0; m < 3; m++) begin m_st[m] = '0; m_bf[m] = '0; end
    set_en(1'b1);
    check_all("R8 clears act while disabled");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset_R9();
    t_shift_latch_R1_R4();
    t_hold_high_R1();
    t_stage_clear_R3();
    t_collide_shift_R3();
    t_buf_clear_R5();
    t_disabled_R6_R7_R8();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule